// File: doc/BRIEF.md
# Banked Destination Register Allocator

This block hands out destination physical register tags to a wide rename stage whose physical register file is split into an even bank and an odd bank. Software never sees the split. Each bank keeps a vector of free entries. On each allocation cycle the block takes the lowest free entries from each bank, one per rename lane pair. Every pair of rename lanes then gets exactly one even-bank tag and one odd-bank tag, so the two micro-ops in a pair always write different banks.

A 16-bit maximal-length LFSR decides, separately for each pair, which of its two lanes gets the odd tag. This keeps repeating code patterns from loading one bank more than the other. Tags freed at commit go back into the free vectors at the clock edge. They can be handed out again from the following cycle on. A tag that is returned in the same cycle as an allocation is therefore never granted twice.

Allocation is all or nothing. If either bank has fewer free entries than there are lane pairs, the block raises a stall and grants nothing that cycle.

Top module: `banked_preg_alloc`

## Requirements
- R1: After reset every entry of both banks is free, `stall` is low, and a request in the first cycle is granted.
- R2: A tag is `TAG_W` bits wide. Bit 0 selects the bank (1 = odd, 0 = even), and bits `TAG_W-1:1` hold the entry index within that bank.
- R3: In a granted cycle, lanes 2k and 2k+1 of pair k carry one odd tag and one even tag.
- R4: Pair k receives the k-th lowest free index of the even bank and the k-th lowest free index of the odd bank, counting from 0.
- R5: `stall` is high exactly when either bank has fewer than `PAIRS` free entries. `grant_valid` equals `alloc_req` and not `stall`. A stalled cycle changes no allocation state.
- R6: Granted tags stop being free at the clock edge that ends the grant cycle. No tag is granted again until it has been freed.
- R7: Each lane with `free_valid` set returns its tag to the free vector at the clock edge. The tag can be granted from the next cycle on, never in the cycle in which it is freed.
- R8: The lane swap of each pair comes from a 16-bit maximal-length LFSR that advances only in granted cycles. Over many grants, every pair sees both orientations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Rename stage asks for a full set of tags this cycle |
| free_valid | input | 2*PAIRS | Per-lane valid bits for returned tags |
| free_tag | input | 2*PAIRS*TAG_W | Returned tags, lane j in bits j*TAG_W upward |
| stall | output | 1 | A bank has too few free entries |
| grant_valid | output | 1 | The tags on grant_tag are allocated this cycle |
| grant_tag | output | 2*PAIRS*TAG_W | Granted tags, lane j in bits j*TAG_W upward |

## Verification
If a free vector is corrupted, the effect reaches the ports in the same cycle the next request arrives. The granted tags stop being the lowest free indices, or a tag that is still in use shows up again, or `stall` appears or disappears at the wrong occupancy. The bench keeps its own copy of both free vectors. It compares every grant and every stall decision against that copy, so one lost or duplicated bit is caught at its first use. A stuck or badly seeded LFSR shows up as a pair that never sees one of its two orientations.

// File: rtl/banked_preg_alloc.sv
module banked_preg_alloc #(
  parameter int PAIRS = 6,
  parameter int BANK_REGS = 32,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  localparam int LANES = 2 * PAIRS,
  localparam int IDX_W = $clog2(BANK_REGS),
  localparam int TAG_W = IDX_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc_req,
  input  logic [LANES-1:0]       free_valid,
  input  logic [LANES*TAG_W-1:0] free_tag,
  output logic                   stall,
  output logic                   grant_valid,
  output logic [LANES*TAG_W-1:0] grant_tag
);
  localparam int CW = $clog2(PAIRS + 1);

  logic [BANK_REGS-1:0] free_q [2];
  logic [BANK_REGS-1:0] take [2];
  logic [BANK_REGS-1:0] give [2];
  logic [IDX_W-1:0]     pick [2][PAIRS];
  logic [1:0]           short_b;
  logic [15:0]          lfsr_q;
  logic [TAG_W-1:0]     lane_tag [LANES];

  always_comb begin
    for (int b = 0; b < 2; b++) begin
      logic [CW-1:0] cnt;
      cnt = '0;
      for (int k = 0; k < PAIRS; k++) pick[b][k] = '0;
      for (int i = 0; i < BANK_REGS; i++) begin
        if (free_q[b][i] && cnt < CW'(PAIRS)) begin
          pick[b][cnt] = IDX_W'(i);
          cnt = cnt + CW'(1);
        end
      end
      short_b[b] = $countones(free_q[b]) < PAIRS;
    end
  end

  assign stall = |short_b;
  assign grant_valid = alloc_req & ~stall;

  always_comb begin
    for (int b = 0; b < 2; b++) begin
      take[b] = '0;
      give[b] = '0;
    end
    if (grant_valid)
      for (int k = 0; k < PAIRS; k++) begin
        take[0][pick[0][k]] = 1'b1;
        take[1][pick[1][k]] = 1'b1;
      end
    for (int j = 0; j < LANES; j++)
      if (free_valid[j])
        give[free_tag[j*TAG_W]][free_tag[j*TAG_W+1 +: IDX_W]] = 1'b1;
  end

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    wire swap = lfsr_q[k % 16];
    assign lane_tag[2*k]   = swap ? {pick[1][k], 1'b1} : {pick[0][k], 1'b0};
    assign lane_tag[2*k+1] = swap ? {pick[0][k], 1'b0} : {pick[1][k], 1'b1};
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign grant_tag[j*TAG_W +: TAG_W] = lane_tag[j];

    assert_granted_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |=> !free_q[$past(lane_tag[j][0])][$past(lane_tag[j][TAG_W-1:1])]);

    assert_free_was_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      free_valid[j] |-> !free_q[free_tag[j*TAG_W]][free_tag[j*TAG_W+1 +: IDX_W]]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q[0] <= '1;
      free_q[1] <= '1;
      lfsr_q <= LFSR_SEED;
    end else begin
      free_q[0] <= (free_q[0] & ~take[0]) | give[0];
      free_q[1] <= (free_q[1] & ~take[1]) | give[1];
      if (grant_valid)
        lfsr_q <= {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[14] ^ lfsr_q[12] ^ lfsr_q[3]};
    end
  end

  assert_idle_holds_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid && !(|free_valid)) |=> ($stable(free_q[0]) && $stable(free_q[1])));

  assert_lfsr_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |=> $stable(lfsr_q));

  assert_lfsr_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 16'h0);
endmodule

// File: tb/banked_preg_alloc_test.sv
module banked_preg_alloc_test;
  localparam int PAIRS = 6;
  localparam int BANK_REGS = 32;
  localparam int LANES = 2 * PAIRS;
  localparam int TAG_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_req = 1'b0;
  logic [LANES-1:0] free_valid = '0;
  logic [LANES*TAG_W-1:0] free_tag = '0;
  logic stall, grant_valid;
  logic [LANES*TAG_W-1:0] grant_tag;

  banked_preg_alloc #(.PAIRS(PAIRS), .BANK_REGS(BANK_REGS)) uut (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .free_valid(free_valid),
    .free_tag(free_tag), .stall(stall), .grant_valid(grant_valid), .grant_tag(grant_tag));

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit mfree [2][BANK_REGS];
  bit busy [2*BANK_REGS];
  bit seen_or [PAIRS][2];
  int exp_pick [2][PAIRS];
  bit exp_stall;
  bit pend_free [2*BANK_REGS];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic void compute_expected();
    exp_stall = 1'b0;
    for (int b = 0; b < 2; b++) begin
      int n = 0;
      for (int k = 0; k < PAIRS; k++) exp_pick[b][k] = 0;
      for (int i = 0; i < BANK_REGS; i++)
        if (mfree[b][i]) begin
          if (n < PAIRS) exp_pick[b][n] = i;
          n++;
        end
      if (n < PAIRS) exp_stall = 1'b1;
    end
  endfunction

  task automatic step(input bit req, input int nfree, input int bank_only);
    int lane;
    @(negedge clk);
    alloc_req = req;
    free_valid = '0;
    free_tag = '0;
    for (int t = 0; t < 2*BANK_REGS; t++) pend_free[t] = 1'b0;
    lane = 0;
    for (int a = 0; a < 4*nfree && lane < nfree; a++) begin
      int t = $urandom_range(2*BANK_REGS-1);
      if (bank_only >= 0) t = (t & ~1) | bank_only;
      if (busy[t] && !pend_free[t]) begin
        pend_free[t] = 1'b1;
        free_valid[lane] = 1'b1;
        free_tag[lane*TAG_W +: TAG_W] = TAG_W'(t);
        lane++;
      end
    end
    #2;
    compute_expected();
    check(stall == exp_stall, "R5 stall", int'(stall), int'(exp_stall));
    check(grant_valid == (req && !exp_stall), "R5 grant_valid", int'(grant_valid),
          int'(req && !exp_stall));
    if (grant_valid && req && !exp_stall) begin
      for (int k = 0; k < PAIRS; k++) begin
        logic [TAG_W-1:0] ta, tb;
        int odd_t, even_t;
        ta = grant_tag[(2*k)*TAG_W +: TAG_W];
        tb = grant_tag[(2*k+1)*TAG_W +: TAG_W];
        check(ta[0] != tb[0], "R3 pair banks", int'(ta), int'(tb));
        odd_t = ta[0] ? int'(ta) : int'(tb);
        even_t = ta[0] ? int'(tb) : int'(ta);
        check(odd_t == 2*exp_pick[1][k] + 1, "R4 odd pick", odd_t, 2*exp_pick[1][k] + 1);
        check(even_t == 2*exp_pick[0][k], "R4 even pick", even_t, 2*exp_pick[0][k]);
        check(!busy[odd_t] && !busy[even_t], "R6 tag not in use", odd_t, even_t);
        seen_or[k][ta[0]] = 1'b1;
      end
      for (int k = 0; k < PAIRS; k++) begin
        mfree[1][exp_pick[1][k]] = 1'b0;
        mfree[0][exp_pick[0][k]] = 1'b0;
        busy[2*exp_pick[1][k]+1] = 1'b1;
        busy[2*exp_pick[0][k]] = 1'b1;
      end
    end
    for (int t = 0; t < 2*BANK_REGS; t++)
      if (pend_free[t]) begin
        busy[t] = 1'b0;
        mfree[t & 1][t >> 1] = 1'b1;
      end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int t = 0; t < 2*BANK_REGS; t++) begin
      busy[t] = 1'b0;
      mfree[t & 1][t >> 1] = 1'b1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(stall == 1'b0, "R1 reset stall", int'(stall), 0);
    check(grant_valid == 1'b0, "R1 idle grant", int'(grant_valid), 0);

    step(1'b1, 0, -1);
    check(grant_tag[TAG_W +: TAG_W] != grant_tag[0 +: TAG_W], "R2 tag encoding", 0, 1);
    repeat (5) step(1'b1, 0, -1);
    check(stall == 1'b1, "R5 drained stall", int'(stall), 1);
    step(1'b1, 8, -1);
    check(grant_valid == 1'b0, "R7 freed not usable same cycle", int'(grant_valid), 0);
    step(1'b1, 0, -1);
    step(1'b1, 6, 1);
    step(1'b1, 0, -1);
    step(1'b0, 0, -1);

    for (int c = 0; c < 3000; c++) begin
      int pct = $urandom_range(99);
      step(pct < 75, $urandom_range(LANES), -1);
    end

    for (int k = 0; k < PAIRS; k++)
      check(seen_or[k][0] && seen_or[k][1], "R8 both orientations", int'(seen_or[k][1]), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule